// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block freezes the current calendar value when an external event fires. Two kinds of event reach it as single-cycle strobes that have already been digitized. An edge strobe means the monitored pin moved to a mid-level, either falling from supply or rising from ground. A ground strobe means the pin was pulled fully low. Either kind latches the whole date/time bus in one clock cycle, so the captured fields always belong together, and sets sticky status flags that software later clears with a write command.

A level-type interrupt request stays high while any flag is pending and the interrupt enable is set. A policy bit chooses what happens when further events arrive before software has cleared the flags: either each event overwrites the stored value, or the first stored value is kept. A global capture-enable input can block all events.

Top module: `evt_stamp_unit`

## Requirements
- R1: With `cap_en` high, an `edge_evt` pulse sets `flag_edge` on the next clock edge and stores the `now_dt` value present in the pulse cycle into `stamp_dt` (when R7 does not block the capture).
- R2: With `cap_en` high, a `gnd_evt` pulse sets both `flag_gnd` and `flag_edge` and stores `now_dt` in the same way.
- R3: `irq` is high exactly when the interrupt enable is 1 and at least one flag is set. Clearing the enable drops `irq` while the flags stay set.
- R4: A cycle with `clr_wr` high clears `flag_edge` if `clr_mask[0]` is 1 and clears `flag_gnd` if `clr_mask[1]` is 1. `irq` stays high until both flags are clear.
- R5: `flag_gnd` is set only by a ground event. An edge event leaves its value unchanged.
- R6: With the keep-first bit at 0, every accepted event overwrites `stamp_dt`, so the newest event is kept.
- R7: With the keep-first bit at 1, an event that arrives while either flag is set (as registered before that cycle) leaves `stamp_dt` unchanged, but still sets its flags. Once both flags are clear, the next event is stored.
- R8: When a clear and an event that sets the same flag fall in one cycle, the event wins and that flag stays set.
- R9: While `cap_en` is low, event strobes change neither the flags nor `stamp_dt`.
- R10: Synchronous active-low reset clears both flags, `stamp_dt`, the interrupt enable and the keep-first bit, so `irq` is 0.
- R11: A cycle with `cfg_wr` high loads the interrupt enable from `cfg_irq_en` and the keep-first bit from `cfg_keep_first`. Both take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en | input | 1 | Global capture enable |
| edge_evt | input | 1 | Single-cycle mid-level edge event strobe |
| gnd_evt | input | 1 | Single-cycle pin-at-ground event strobe |
| now_dt | input | DT_W | Current packed date/time |
| clr_wr | input | 1 | Flag clear command strobe |
| clr_mask | input | 2 | Bit 0 clears `flag_edge`, bit 1 clears `flag_gnd` |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_irq_en | input | 1 | Interrupt enable value to load |
| cfg_keep_first | input | 1 | Keep-first policy value to load |
| stamp_dt | output | DT_W | Captured date/time |
| flag_edge | output | 1 | Sticky flag for any accepted event |
| flag_gnd | output | 1 | Sticky flag for ground events |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets the cases where the interrupt must outlive a partial clear. A design that dropped `irq` on the first flag clear after a ground event would fail there. It also drives a clear and an event in the same cycle: a design that let the clear win would lose the event, and one that let an edge event set the ground flag would show a wrong `flag_gnd`. In keep-first mode, it checks that a pending flag freezes the stored value and that a full clear unfreezes it, which catches a policy test made against the wrong flag set. A reset taken during the run must also restore the configuration bits, which catches an interrupt or overwrite policy that survives reset.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLG_EDGE  = 0;
  localparam int unsigned FLG_GND   = 1;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  // A capture is allowed unless the keep-first policy is active and
  // an earlier event is still unacknowledged.
  function automatic logic f_may_store(input logic keep_first,
                                       input logic pending);
    return !(keep_first && pending);
  endfunction

  // Sticky bit update: a set request outranks a clear request.
  function automatic logic f_sticky_next(input logic cur,
                                         input logic set_req,
                                         input logic clr_req);
    logic nxt;
    nxt = cur;
    if (clr_req) nxt = 1'b0;
    if (set_req) nxt = 1'b1;
    return nxt;
  endfunction

  // Interrupt level from enable and pending status.
  function automatic logic f_irq_level(input logic en,
                                       input flag_vec_t flags);
    return en && (|flags);
  endfunction

endpackage

// File: rtl/evt_ctrl_regs.sv
module evt_ctrl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_irq_en,
  input  logic cfg_keep_first,
  output logic irq_en_q,
  output logic keep_first_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en_q     <= 1'b0;
      keep_first_q <= 1'b0;
    end else if (cfg_wr) begin
      irq_en_q     <= cfg_irq_en;
      keep_first_q <= cfg_keep_first;
    end
  end

endmodule

// File: rtl/evt_trig_qual.sv
module evt_trig_qual
  import evt_stamp_pkg::*;
(
  input  logic      cap_en,
  input  logic      edge_evt,
  input  logic      gnd_evt,
  input  logic      clr_wr,
  input  logic [1:0] clr_mask,
  input  logic      keep_first,
  input  flag_vec_t flags_q,
  output flag_vec_t set_req,
  output flag_vec_t clr_req,
  output logic      store_hit
);

  logic edge_ok;
  logic gnd_ok;
  logic any_ok;

  always_comb begin
    edge_ok = cap_en && edge_evt;
    gnd_ok  = cap_en && gnd_evt;
    any_ok  = edge_ok || gnd_ok;

    set_req           = '0;
    set_req[FLG_EDGE] = any_ok;
    set_req[FLG_GND]  = gnd_ok;

    clr_req           = '0;
    clr_req[FLG_EDGE] = clr_wr && clr_mask[0];
    clr_req[FLG_GND]  = clr_wr && clr_mask[1];

    store_hit = any_ok && f_may_store(keep_first, |flags_q);
  end

endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
  import evt_stamp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_req,
  input  flag_vec_t clr_req,
  input  logic      irq_en,
  output flag_vec_t flags_q,
  output logic      irq
);

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags_q[g] <= 1'b0;
      else        flags_q[g] <= f_sticky_next(flags_q[g], set_req[g], clr_req[g]);
    end
  end

  assign irq = f_irq_level(irq_en, flags_q);

endmodule

// File: rtl/evt_stamp_store.sv
module evt_stamp_store #(
  parameter int unsigned DT_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            store_hit,
  input  logic [DT_W-1:0] now_dt,
  output logic [DT_W-1:0] stamp_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)         stamp_q <= '0;
    else if (store_hit) stamp_q <= now_dt;
  end

endmodule

// File: rtl/evt_stamp_unit.sv
module evt_stamp_unit
  import evt_stamp_pkg::*;
#(
  parameter int unsigned DT_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic            edge_evt,
  input  logic            gnd_evt,
  input  logic [DT_W-1:0] now_dt,
  input  logic            clr_wr,
  input  logic [1:0]      clr_mask,
  input  logic            cfg_wr,
  input  logic            cfg_irq_en,
  input  logic            cfg_keep_first,
  output logic [DT_W-1:0] stamp_dt,
  output logic            flag_edge,
  output logic            flag_gnd,
  output logic            irq
);

  logic      irq_en_q;
  logic      keep_first_q;
  flag_vec_t flags_q;
  flag_vec_t set_req;
  flag_vec_t clr_req;
  logic      store_hit;

  evt_ctrl_regs u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_irq_en     (cfg_irq_en),
    .cfg_keep_first (cfg_keep_first),
    .irq_en_q       (irq_en_q),
    .keep_first_q   (keep_first_q)
  );

  evt_trig_qual u_qual (
    .cap_en     (cap_en),
    .edge_evt   (edge_evt),
    .gnd_evt    (gnd_evt),
    .clr_wr     (clr_wr),
    .clr_mask   (clr_mask),
    .keep_first (keep_first_q),
    .flags_q    (flags_q),
    .set_req    (set_req),
    .clr_req    (clr_req),
    .store_hit  (store_hit)
  );

  evt_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (set_req),
    .clr_req (clr_req),
    .irq_en  (irq_en_q),
    .flags_q (flags_q),
    .irq     (irq)
  );

  evt_stamp_store #(.DT_W(DT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .store_hit (store_hit),
    .now_dt    (now_dt),
    .stamp_q   (stamp_dt)
  );

  assign flag_edge = flags_q[FLG_EDGE];
  assign flag_gnd  = flags_q[FLG_GND];

endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk #(
  parameter int unsigned DT_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cap_en,
  input logic            edge_evt,
  input logic            gnd_evt,
  input logic [DT_W-1:0] now_dt,
  input logic            clr_wr,
  input logic [1:0]      clr_mask,
  input logic [DT_W-1:0] stamp_dt,
  input logic            flag_edge,
  input logic            flag_gnd,
  input logic            irq,
  input logic            irq_en_q,
  input logic            keep_first_q,
  input logic            store_hit
);

  // R1
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && edge_evt) |=> flag_edge);

  // R2
  gnd_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && gnd_evt) |=> (flag_gnd && flag_edge));

  // R3
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_edge && !flag_gnd) |-> !irq);

  // R3
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_q |-> !irq);

  // R4
  clr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_mask[0] && !(cap_en && (edge_evt || gnd_evt))) |=> !flag_edge);

  // R5
  gnd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cap_en && gnd_evt) && !flag_gnd) |=> !flag_gnd);

  // R6
  stamp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_hit |=> (stamp_dt == $past(now_dt)));

  // R7
  keep_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_first_q && (flag_edge || flag_gnd)) |=> $stable(stamp_dt));

  // R9
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !store_hit) |=> $stable(stamp_dt));

endmodule

bind evt_stamp_unit evt_stamp_chk #(.DT_W(DT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cap_en       (cap_en),
  .edge_evt     (edge_evt),
  .gnd_evt      (gnd_evt),
  .now_dt       (now_dt),
  .clr_wr       (clr_wr),
  .clr_mask     (clr_mask),
  .stamp_dt     (stamp_dt),
  .flag_edge    (flag_edge),
  .flag_gnd     (flag_gnd),
  .irq          (irq),
  .irq_en_q     (irq_en_q),
  .keep_first_q (keep_first_q),
  .store_hit    (store_hit)
);

// File: tb/test_evt_stamp_unit.sv
module test_evt_stamp_unit;

  localparam int unsigned DT_W = 48;
  localparam int unsigned NV   = 20;

  // [47:44] req tag, [43] cap_en, [42] edge, [41] gnd, [40] clr_wr,
  // [39:38] clr_mask, [37] cfg_wr, [36] irq_en, [35] keep_first,
  // [34:19] dt, [18] exp flag_edge, [17] exp flag_gnd, [16] exp irq,
  // [15:0] exp stamp
  function automatic logic [47:0] v(input logic [3:0] tag,
      input logic c, input logic e, input logic g, input logic cw,
      input logic [1:0] m, input logic fw, input logic ie, input logic kf,
      input logic [15:0] dt, input logic fe, input logic fg, input logic iq,
      input logic [15:0] st);
    return {tag, c, e, g, cw, m, fw, ie, kf, dt, fe, fg, iq, st};
  endfunction

  localparam logic [47:0] VEC [NV] = '{
    v(4'd11, 0,0,0, 0,2'b00, 1,1,0, 16'h1111, 0,0,0, 16'h0000), // R11 cfg irq on
    v(4'd1,  1,1,0, 0,2'b00, 0,0,0, 16'h1234, 1,0,1, 16'h1234), // R1 edge
    v(4'd6,  1,1,0, 0,2'b00, 0,0,0, 16'h2222, 1,0,1, 16'h2222), // R6 overwrite
    v(4'd4,  1,0,0, 1,2'b01, 0,0,0, 16'h0000, 0,0,0, 16'h2222), // R4 clear edge
    v(4'd2,  1,0,1, 0,2'b00, 0,0,0, 16'h3333, 1,1,1, 16'h3333), // R2 ground
    v(4'd4,  1,0,0, 1,2'b01, 0,0,0, 16'h0000, 0,1,1, 16'h3333), // R4 irq held
    v(4'd4,  1,0,0, 1,2'b10, 0,0,0, 16'h0000, 0,0,0, 16'h3333), // R4 all clear
    v(4'd9,  0,1,0, 0,2'b00, 0,0,0, 16'h4444, 0,0,0, 16'h3333), // R9 edge blocked
    v(4'd9,  0,0,1, 0,2'b00, 0,0,0, 16'h4545, 0,0,0, 16'h3333), // R9 gnd blocked
    v(4'd11, 1,0,0, 0,2'b00, 1,1,1, 16'h0000, 0,0,0, 16'h3333), // R11 keep first
    v(4'd7,  1,1,0, 0,2'b00, 0,0,0, 16'h5555, 1,0,1, 16'h5555), // R7 first stored
    v(4'd7,  1,0,1, 0,2'b00, 0,0,0, 16'h6666, 1,1,1, 16'h5555), // R7 kept
    v(4'd8,  1,1,0, 1,2'b11, 0,0,0, 16'h7777, 1,0,1, 16'h5555), // R8 event wins
    v(4'd4,  1,0,0, 1,2'b11, 0,0,0, 16'h0000, 0,0,0, 16'h5555), // R4 both clear
    v(4'd7,  1,0,1, 0,2'b00, 0,0,0, 16'h8888, 1,1,1, 16'h8888), // R7 store again
    v(4'd3,  1,0,0, 0,2'b00, 1,0,1, 16'h0000, 1,1,0, 16'h8888), // R3 enable off
    v(4'd3,  1,0,0, 0,2'b00, 1,1,0, 16'h0000, 1,1,1, 16'h8888), // R3 enable on
    v(4'd5,  1,1,0, 0,2'b00, 0,0,0, 16'h9999, 1,1,1, 16'h9999), // R5 gnd kept
    v(4'd8,  1,0,1, 1,2'b10, 0,0,0, 16'hAAAA, 1,1,1, 16'hAAAA), // R8 gnd wins
    v(4'd4,  1,0,0, 1,2'b11, 0,0,0, 16'h0000, 0,0,0, 16'hAAAA)  // R4 clear
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cap_en, edge_evt, gnd_evt, clr_wr, cfg_wr;
  logic            cfg_irq_en, cfg_keep_first;
  logic [1:0]      clr_mask;
  logic [DT_W-1:0] now_dt;
  logic [DT_W-1:0] stamp_dt;
  logic            flag_edge, flag_gnd, irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  evt_stamp_unit #(.DT_W(DT_W)) i_evt_stamp_unit (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .edge_evt(edge_evt),
    .gnd_evt(gnd_evt), .now_dt(now_dt), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .cfg_wr(cfg_wr), .cfg_irq_en(cfg_irq_en), .cfg_keep_first(cfg_keep_first),
    .stamp_dt(stamp_dt), .flag_edge(flag_edge), .flag_gnd(flag_gnd), .irq(irq)
  );

  function automatic logic [DT_W-1:0] widen(input logic [15:0] d);
    return {d, d, d};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [DT_W-1:0] act, input logic [DT_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cap_en = 1'b1; edge_evt = 1'b0; gnd_evt = 1'b0; clr_wr = 1'b0;
    clr_mask = 2'b00; cfg_wr = 1'b0; cfg_irq_en = 1'b0;
    cfg_keep_first = 1'b0; now_dt = '0;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "flag_edge", {47'd0, flag_edge}, '0);
    chk("R10", "flag_gnd",  {47'd0, flag_gnd},  '0);
    chk("R10", "irq",       {47'd0, irq},       '0);
    chk("R10", "stamp",     stamp_dt,           '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [47:0] r;
      r = VEC[i];
      tag = $sformatf("R%0d/row%0d", r[47:44], i);
      cap_en = r[43]; edge_evt = r[42]; gnd_evt = r[41]; clr_wr = r[40];
      clr_mask = r[39:38]; cfg_wr = r[37]; cfg_irq_en = r[36];
      cfg_keep_first = r[35]; now_dt = widen(r[34:19]);
      step();
      chk(tag, "flag_edge", {47'd0, flag_edge}, {47'd0, r[18]});
      chk(tag, "flag_gnd",  {47'd0, flag_gnd},  {47'd0, r[17]});
      chk(tag, "irq",       {47'd0, irq},       {47'd0, r[16]});
      chk(tag, "stamp",     stamp_dt,           widen(r[15:0]));
      idle_inputs();
    end

    // R10 reset in mid run restores flags, stamp and configuration
    cfg_wr = 1'b1; cfg_irq_en = 1'b1; cfg_keep_first = 1'b1;
    step();
    idle_inputs();
    gnd_evt = 1'b1; now_dt = widen(16'hBEEF);
    step();
    idle_inputs();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    chk("R10", "flag_edge after reset", {47'd0, flag_edge}, '0);
    chk("R10", "flag_gnd after reset",  {47'd0, flag_gnd},  '0);
    chk("R10", "stamp after reset",     stamp_dt,           '0);
    edge_evt = 1'b1; now_dt = widen(16'h0101);
    step();
    idle_inputs();
    chk("R10", "irq enable cleared", {47'd0, irq}, '0);
    chk("R1", "flag after reset", {47'd0, flag_edge}, 48'd1);
    edge_evt = 1'b1; now_dt = widen(16'h0202);
    step();
    idle_inputs();
    chk("R10", "keep-first cleared so overwrite", stamp_dt, widen(16'h0202));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule